// File: doc/BRIEF.md
# Iterative Shift-and-Add Multiplier

This block multiplies two 32-bit operands into a 64-bit product, handling one multiplier bit per clock. A request is made by raising `start` while the block is idle, together with the two operands and a mode select that chooses between unsigned and two's-complement arithmetic. The block then runs 32 iterations. In each one it tests the low bit of a right-shifting multiplier register. When that bit is set, it adds a left-shifting, double-width copy of the multiplicand into a 64-bit accumulator.

Signed requests reuse the unsigned datapath. Both operands are reduced to their magnitudes when the request is accepted. The finished sum is negated if exactly one operand was negative. The result lands in a result register whose upper and lower words are presented on separate ports. It keeps its value until the next operation completes. `done` marks completion with a single-cycle pulse.

Top module: `seq_mult`

## Requirements
- R1: While reset is asserted and just after it, `busy` and `done` are 0 and both `prod_hi` and `prod_lo` are 0.
- R2: A `start` seen at a clock edge while `busy` is 0 sets `busy` at that edge. `busy` stays high for exactly 32 cycles, and `done` rises at the edge where `busy` falls.
- R3: `done` is high for exactly one cycle per operation, and `busy` is 0 whenever `done` is 1.
- R4: With `is_signed` = 0, `{prod_hi, prod_lo}` equals the unsigned 64-bit product of `op_a` and `op_b`.
- R5: With `is_signed` = 1, `{prod_hi, prod_lo}` equals the two's-complement 64-bit product. This includes operands equal to the most negative 32-bit value and the all-ones value (-1).
- R6: `prod_hi` and `prod_lo` change only at the edge that raises `done`, and they hold their value in every other cycle.
- R7: A `start` that arrives while `busy` is 1 is ignored. The running operation finishes on its original schedule with its original result.
- R8: `op_a`, `op_b` and `is_signed` are sampled only at the edge that accepts `start`. Changes to them during the operation do not affect the result.
- R9: A `start` presented in the cycle where `done` is high is accepted at the next edge. This makes back-to-back operations possible with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a multiply; taken only when idle |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prod_hi | output | 32 | Upper word of the last product |
| prod_lo | output | 32 | Lower word of the last product |

## Verification
Three situations are hard to reach from the ports.

- A second request that lands in the middle of an iteration run must be shown to be ignored. The bench therefore pulses `start` with different operands and mode several cycles after a request has been accepted.
- The operand inputs must be shown to be unused after acceptance. The bench scrambles the operands and flips the mode while the block is busy.
- Back-to-back issue depends on a request being presented in exactly the `done` cycle. The bench watches for `done` at the falling edge and raises `start` right there.

The sign-correction path is driven with the most negative value against itself, against 1 and against -1. These are the cases where the magnitude fills the full word.

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W) + 1;

  logic [PW-1:0] mcand_q, acc_q, res_q;
  logic [W-1:0]  mplier_q;
  logic [CW-1:0] step_q;
  logic          neg_q, busy_q, done_q;

  wire          a_neg = is_signed & op_a[W-1];
  wire          b_neg = is_signed & op_b[W-1];
  wire [W-1:0]  a_mag = a_neg ? -op_a : op_a;
  wire [W-1:0]  b_mag = b_neg ? -op_b : op_b;
  wire [PW-1:0] sum   = acc_q + (mplier_q[0] ? mcand_q : '0);
  wire [PW-1:0] fin   = neg_q ? -sum : sum;
  wire          last  = (step_q == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      acc_q    <= '0;
      res_q    <= '0;
      mplier_q <= '0;
      step_q   <= '0;
      neg_q    <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        acc_q    <= sum;
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        step_q   <= step_q + CW'(1);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= fin;
        end
      end else if (start) begin
        mcand_q  <= {{W{1'b0}}, a_mag};
        mplier_q <= b_mag;
        acc_q    <= '0;
        step_q   <= '0;
        neg_q    <= a_neg ^ b_neg;
        busy_q   <= 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign prod_hi = res_q[PW-1:W];
  assign prod_lo = res_q[W-1:0];
endmodule

// File: rtl/seq_mult_chk.sv
module seq_mult_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_run == W));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({prod_hi, prod_lo}));

  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind seq_mult seq_mult_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
);

// File: tb/seq_mult_bench.sv
`timescale 1ns/1ps
module seq_mult_bench;
  localparam int W = 32;

  logic clk = 0, rst_n = 0, start = 0, is_signed = 0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic busy, done;
  logic [W-1:0] prod_hi, prod_lo;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R4";

  always #2.5 clk = ~clk;

  seq_mult #(.W(W)) u_seq_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
    .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  // behavioural reference
  logic        m_busy = 0, m_done = 0;
  int          m_cnt = 0;
  logic [63:0] m_pend = '0, m_res = '0;

  function automatic logic [63:0] ref_mul(input logic [31:0] a, b, input logic s);
    longint sa, sb;
    if (s) begin
      sa = longint'(signed'(a));
      sb = longint'(signed'(b));
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == W) begin
          m_busy = 0; m_done = 1; m_res = m_pend;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0;
        m_pend = ref_mul(op_a, op_b, is_signed);
      end
    end
  end

  task automatic check(input string t, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 busy", 64'(busy), 64'(m_busy));
      check("R3 done", 64'(done), 64'(m_done));
      check(m_done ? tag : "R6", {prod_hi, prod_lo}, m_res);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic issue(input logic [31:0] a, b, input logic s);
    op_a = a; op_b = b; is_signed = s; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] a, b, input logic s, input string t);
    tag = t;
    issue(a, b, s);
    wait_done();
    @(negedge clk);
  endtask

  logic [31:0] lcg = 32'h1234_5678;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {30'b0, busy, done}, 64'b0);
    check("R1 reset product", {prod_hi, prod_lo}, 64'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", {prod_hi, prod_lo}, 64'b0);

    // R4 unsigned
    run(32'd0, 32'hDEAD_BEEF, 0, "R4");
    run(32'd1000, 32'd1001, 0, "R4");
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R4");
    run(32'hAAAA_AAAA, 32'h5555_5555, 0, "R4");
    run(32'h8000_0000, 32'h0000_0002, 0, "R4");
    // R5 signed
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R5");
    run(32'h8000_0000, 32'h8000_0000, 1, "R5");
    run(32'h8000_0000, 32'd1, 1, "R5");
    run(32'h8000_0000, 32'hFFFF_FFFF, 1, "R5");
    run(32'd7, 32'hFFFF_FFFE, 1, "R5");
    run(32'hFFFF_FFF9, 32'd12345, 1, "R5");
    run(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, "R5");
    for (int i = 0; i < 8; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      op_b = lcg;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      run(lcg, op_b, i[0], i[0] ? "R5" : "R4");
    end

    // R7: start while busy is ignored
    tag = "R7";
    issue(32'd3, 32'd5, 0);
    repeat (4) @(negedge clk);
    issue(32'hFFFF_FFFF, 32'h8000_0000, 1);
    repeat (10) @(negedge clk);
    issue(32'h0000_1111, 32'h0000_2222, 0);
    wait_done();
    check("R7 result of first request", {prod_hi, prod_lo}, 64'd15);
    @(negedge clk);

    // R8: operands and mode changed during the run
    tag = "R8";
    issue(32'hFFFF_FFFE, 32'd9, 1);
    op_a = 32'h1234_5678; op_b = 32'h9ABC_DEF0; is_signed = 0;
    repeat (20) @(negedge clk);
    op_a = 32'hFFFF_FFFF; is_signed = 1;
    wait_done();
    check("R8 sampled operands", {prod_hi, prod_lo}, 64'hFFFF_FFFF_FFFF_FFEE);
    @(negedge clk);

    // R9: back-to-back issue in the done cycle
    tag = "R9";
    issue(32'd6, 32'd7, 0);
    wait_done();
    issue(32'hFFFF_FFFD, 32'd4, 1);
    check("R9 accepted after done", 64'(busy), 64'd1);
    wait_done();
    check("R9 second product", {prod_hi, prod_lo}, 64'hFFFF_FFFF_FFFF_FFF4);
    @(negedge clk);
    issue(32'd2, 32'd2, 0);
    wait_done();
    issue(32'd9, 32'd9, 0);
    wait_done();
    check("R9 third product", {prod_hi, prod_lo}, 64'd81);
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule